// File: doc/BRIEF.md
# Clocked Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous byte-wide static RAM. The host asks for one word at a time: it raises `req` for a clock with `we`, `addr` and `wdata` set. The controller then runs the strobe sequence the memory needs and pulses `ready` once the access is finished. For a read, `rdata` holds the word that was returned.

Each phase of the sequence has its own length in clock cycles. These lengths come from nanosecond limits given as parameters, together with the clock period: count = ceil(ns / period), and never less than one. The phases are address setup before the write strobe, write strobe width, bus turnaround before the controller drives data, data setup, data and address hold, read access, and read recovery. The strobes decode directly from the state register. The address and the write data are registered.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `mem_sel_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_drive` and `ready` are 0.
- R2: A write keeps `mem_sel_n` low with `mem_we_n` high for exactly C_AS cycles. It then holds `mem_we_n` low for exactly C_WPL = max(C_WP, C_TURN + C_DS) cycles.
- R3: `mem_drive` is 1 only while `mem_oe_n` is 1. During a write it rises exactly C_TURN cycles after `mem_we_n` falls.
- R4: `mem_wdata` is stable while `mem_drive` is 1, and `mem_drive` is still 1 in the cycle where `mem_we_n` returns high.
- R5: `mem_we_n` and `mem_oe_n` are never both 0.
- R6: A read holds `mem_oe_n` low for C_RACC = max(C_AA, C_OE) cycles. `rdata` presents the value of `mem_rdata` from the last of those cycles.
- R7: `mem_addr` does not change while `mem_sel_n` stays low. It equals the address of the accepted request.
- R8: A request made while an access is in progress is ignored. It writes nothing and does not change the timing of the access in progress.
- R9: `ready` is high for a single cycle per access. Counting the clock edge that accepts the request as edge 1, `ready` is seen after edge C_AS + C_WPL + C_HOLD + 1 for a write and after edge C_RACC + C_RREC + 1 for a read.
- R10: C_HOLD = max(C_AH, C_DH, C_WC − C_AS − C_WPL, 1) and C_RREC = max(C_TURN, C_RC − C_RACC). Every base count is ceil(ns / CLK_NS) with a floor of 1. At the defaults (20 ns clock) both reads and writes take 7 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, taken only when the controller is idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data from the last read |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wdata | output | DATA_W | Data to the memory bus |
| mem_drive | output | 1 | Enables the controller's bus driver |
| mem_rdata | input | DATA_W | Data from the memory bus |

## Verification
The bench drives a behavioural memory that stores data on the rising edge of the write strobe. That memory returns a marker value whenever its output enable is off. A controller that samples read data one cycle early or late, or after releasing output enable, therefore returns the marker and not the stored byte. Per-cycle monitors measure the setup run, the strobe width and the turnaround before drive. A design that turns on its driver as soon as the strobe falls, or that cuts the pulse short, shows up as a wrong count. A request placed in the middle of a write targets an address that is never written otherwise. If the controller accepts that request, the byte read back later is wrong and the access latency changes.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 20,
  parameter int T_AS_NS = 0,
  parameter int T_WP_NS = 65,
  parameter int T_TURN_NS = 30,
  parameter int T_DS_NS = 30,
  parameter int T_DH_NS = 0,
  parameter int T_AH_NS = 5,
  parameter int T_WC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 40,
  parameter int T_RC_NS = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_drive,
  input  logic [DATA_W-1:0] mem_rdata
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_AS   = cyc(T_AS_NS);
  localparam int C_TURN = cyc(T_TURN_NS);
  localparam int C_WPL  = mx(cyc(T_WP_NS), C_TURN + cyc(T_DS_NS));
  localparam int C_HOLD = mx(mx(cyc(T_AH_NS), cyc(T_DH_NS)), mx(cyc(T_WC_NS) - C_AS - C_WPL, 1));
  localparam int C_RACC = mx(cyc(T_AA_NS), cyc(T_OE_NS));
  localparam int C_RREC = mx(C_TURN, cyc(T_RC_NS) - C_RACC);
  localparam int C_MAX  = mx(mx(mx(C_AS, C_WPL), mx(C_HOLD, C_RACC)), C_RREC);
  localparam int CNT_W  = $clog2(C_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSU, S_WPL, S_WHD, S_RAC, S_RRC, S_DONE} state_t;

  state_t             state, nxt;
  logic [CNT_W-1:0]   cnt, lim;

  always_comb begin
    lim = '0;
    nxt = S_IDLE;
    case (state)
      S_WSU: begin lim = CNT_W'(C_AS - 1);   nxt = S_WPL;  end
      S_WPL: begin lim = CNT_W'(C_WPL - 1);  nxt = S_WHD;  end
      S_WHD: begin lim = CNT_W'(C_HOLD - 1); nxt = S_DONE; end
      S_RAC: begin lim = CNT_W'(C_RACC - 1); nxt = S_RRC;  end
      S_RRC: begin lim = CNT_W'(C_RREC - 1); nxt = S_DONE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rdata     <= '0;
    end else begin
      case (state)
        S_IDLE: if (req) begin
          mem_addr  <= addr;
          mem_wdata <= wdata;
          cnt       <= '0;
          state     <= we ? S_WSU : S_RAC;
        end
        S_DONE: state <= S_IDLE;
        default: begin
          if (cnt == lim) begin
            cnt   <= '0;
            state <= nxt;
            if (state == S_RAC) rdata <= mem_rdata;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign mem_sel_n = (state == S_IDLE) || (state == S_DONE);
  assign mem_we_n  = (state != S_WPL);
  assign mem_oe_n  = (state != S_RAC);
  assign mem_drive = ((state == S_WPL) && (cnt >= CNT_W'(C_TURN))) || (state == S_WHD);
  assign ready     = (state == S_DONE);
endmodule

module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_drive
);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_drive_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> mem_oe_n);

  p_drive_at_we_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_drive);

  p_wdata_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_drive && $past(mem_drive)) |-> $stable(mem_wdata));

  p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .mem_addr(mem_addr),
  .mem_sel_n(mem_sel_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_wdata(mem_wdata), .mem_drive(mem_drive)
);

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int CK = 20;

  function automatic int cy(input int ns);
    int c;
    c = (ns + CK - 1) / CK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_AS   = cy(0);
  localparam int E_TURN = cy(30);
  localparam int E_WPL  = mx(cy(65), E_TURN + cy(30));
  localparam int E_HOLD = mx(mx(cy(5), cy(0)), mx(cy(70) - E_AS - E_WPL, 1));
  localparam int E_RACC = mx(cy(70), cy(40));
  localparam int E_RREC = mx(E_TURN, cy(70) - E_RACC);
  localparam int E_WLAT = E_AS + E_WPL + E_HOLD + 1;
  localparam int E_RLAT = E_RACC + E_RREC + 1;
  localparam logic [AW-1:0] POKE_A = 12'hFFE;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, mem_sel_n, mem_we_n, mem_oe_n, mem_drive;
  logic [DW-1:0] rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] sram [0:(1<<AW)-1];
  logic [DW-1:0] refm [0:(1<<AW)-1];
  int checks = 0, failures = 0, cycles = 0;
  int su = 0, wrun = 0, pd = 0;
  logic [AW-1:0] held_a = '0;
  logic sel_prev = 1'b1;

  always #(CK/2) clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_wdata(mem_wdata),
    .mem_drive(mem_drive), .mem_rdata(mem_rdata)
  );

  always @(posedge mem_we_n) if (mem_sel_n === 1'b0 && mem_drive === 1'b1) sram[mem_addr] = mem_wdata;
  assign mem_rdata = (!mem_sel_n && !mem_oe_n) ? sram[mem_addr] : 8'hEE;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && !mem_oe_n) chk(0, "R5 strobes both low", 0, 1);
    if (mem_drive && !mem_oe_n) chk(0, "R3 drive with oe low", 0, 1);
    if (!mem_sel_n && !sel_prev && mem_addr != held_a) chk(0, "R7 addr moved", mem_addr, held_a);
    if (!mem_sel_n && sel_prev) held_a = mem_addr;
    sel_prev = mem_sel_n;
    if (mem_sel_n) begin su = 0; wrun = 0; pd = 0; end
    else if (!mem_we_n) begin wrun++; if (!mem_drive) pd++; end
    else if (wrun > 0) begin
      chk(wrun == E_WPL, "R2 we pulse width", wrun, E_WPL);
      chk(su == E_AS, "R2 addr setup", su, E_AS);
      chk(pd == E_TURN, "R3 turnaround", pd, E_TURN);
      chk(mem_drive, "R4 data held at we rise", mem_drive, 1);
      wrun = 0; su = 99;
    end else su++;
  end

  task automatic txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int n;
    bit got;
    n = 0; got = 0;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    for (int i = 0; i < 40 && !got; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (poke && i == 2) begin req = 1; we = 1; addr = POKE_A; wdata = 8'h5A; end
      else req = 0;
      if (ready) got = 1;
    end
    req = 0;
    chk(got && n == (w ? E_WLAT : E_RLAT), w ? "R9 write latency" : "R9 read latency", n, w ? E_WLAT : E_RLAT);
    if (w) refm[a] = d;
    else chk(rdata == refm[a], (a == POKE_A) ? "R8 busy request ignored" : "R6 read data", rdata, refm[a]);
    @(negedge clk);
    chk(!ready, "R9 ready single pulse", ready, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin sram[i] = '0; refm[i] = '0; end
    void'($urandom(32'd4471));
    repeat (3) @(negedge clk);
    chk(mem_sel_n && mem_we_n && mem_oe_n && !mem_drive && !ready, "R1 reset outputs",
        {mem_sel_n, mem_we_n, mem_oe_n, mem_drive, ready}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(mem_sel_n && mem_we_n && mem_oe_n && !mem_drive && !ready, "R1 after reset",
        {mem_sel_n, mem_we_n, mem_oe_n, mem_drive, ready}, 5'b11100);
    chk(E_WLAT == 7 && E_RLAT == 7, "R10 derived counts", E_WLAT * 16 + E_RLAT, 7 * 16 + 7);
    txn(1, 12'h000, 8'h00, 0);
    txn(1, 12'hFFF, 8'hFF, 0);
    txn(0, 12'h000, 8'h00, 0);
    txn(0, 12'hFFF, 8'h00, 0);
    txn(1, 12'h123, 8'hA5, 1);
    txn(0, POKE_A, 8'h00, 0);
    txn(0, 12'h123, 8'h00, 1);
    txn(0, POKE_A, 8'h00, 0);
    txn(1, 12'h001, 8'h3C, 0);
    txn(1, 12'h001, 8'hC3, 0);
    txn(0, 12'h001, 8'h00, 0);
    for (int k = 0; k < 150; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 63));
      txn(1'($urandom_range(0, 1)), a, DW'($urandom), 0);
    end
    txn(0, POKE_A, 8'h00, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule